// File: doc/BRIEF.md
# Buffered Period-Timer PWM Channel

A single-channel pulse-width modulator built around an 8-bit period timer. A unified clock divider feeds the timer at one quarter of the system clock rate, divided further by 1, 4 or 16. The two divider bits just below the timer count form a 2-bit fine count, so the duty compare has 10 bits of resolution. A period register sets the length of each cycle. A 10-bit duty value sets how long the output stays high at the start of each cycle.

Software writes four byte-wide registers through a simple write port. The duty value never reaches the comparator directly. It is copied into a shadow register only at a period boundary, so a write in mid-cycle cannot shorten or stretch the pulse that is already running. Each period match also advances a postscaler. After a programmable number of matches it emits a one-cycle interrupt pulse.

Top module: `pwm_gen`

## Requirements
- R1: Writes with `wr_en_i` high select a register by `wr_addr_i`, as follows.
  - Address 0 is the period P.
  - Address 1 holds duty bits 9:2.
  - Address 2 holds duty bits 1:0 in data bits 5:4. Its other bits are ignored.
  - Address 3 is timer control. Bits 1:0 pick the prescale N: 00 gives 1, 01 gives 4, 1x gives 16. Bit 2 enables the timer. Bits 6:3 hold the postscale value S.
- R2: While enabled, one PWM period lasts (P+1)·4·N system clock cycles.
- R3: For a shadow duty D with 0 < D < 4·(P+1), `pwm_o` goes high in the first cycle of a period and stays high for exactly D·N cycles.
- R4: A duty written during a period takes effect only from the next period boundary. The running period keeps the previous duty.
- R5: A duty of zero keeps `pwm_o` low for the whole period.
- R6: A duty of 4·(P+1) or more keeps `pwm_o` high for the whole period.
- R7: While the timer is disabled:
  - `pwm_o` is low, and the timer and divider hold their values.
  - No interrupt is raised.
  - Register writes are still accepted and take effect after re-enabling.
- R8: `irq_o` is a one-cycle pulse in the first cycle of every (S+1)-th period.
- R9: After reset, `pwm_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Postscaled period-match pulse |

## Verification
Some properties are checked on every cycle:
- the output rises only at a period wrap;
- the output stays low whenever the shadow duty is zero or the timer was disabled in the previous cycle;
- the timer holds when no tick arrives;
- the shadow changes only at a wrap;
- the interrupt never lasts two cycles.

Other behaviour can only be shown by the bench scenarios, because it needs the cycles to be counted over whole periods. This covers the exact high time and period length for each prescale setting, the full-on and full-off duty extremes, the one-period delay of a mid-cycle duty write, and the spacing of interrupts under the postscaler.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int TMR_W  = 8;
  localparam int FINE_W = 2;
  localparam int DUTY_W = TMR_W + FINE_W;
  localparam int POST_W = 4;
  localparam int PRE_W  = 2;
  // divider spans 4*16 cycles at the largest prescale
  localparam int DIV_W  = FINE_W + 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PERIOD  = 2'd0,
    ADDR_DUTY_HI = 2'd1,
    ADDR_CHAN    = 2'd2,
    ADDR_TCTRL   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [POST_W-1:0] post_sel;
    logic              en;
    logic [PRE_W-1:0]  pre_sel;
  } tctrl_t;

  localparam int CHAN_LSB = 4;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  pre_sel_i,
  output logic              tick_o,
  output logic [FINE_W-1:0] fine_nxt_o
);
  logic [DIV_W-1:0] div_q, div_d, last;

  always_comb begin
    case (pre_sel_i)
      2'b00:   last = DIV_W'(4 - 1);
      2'b01:   last = DIV_W'(16 - 1);
      default: last = DIV_W'(64 - 1);
    endcase
  end

  // >= recovers if the prescale shrinks mid-tick
  assign tick_o = en_i && (div_q >= last);

  always_comb begin
    if (!en_i)       div_d = div_q;
    else if (tick_o) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_comb begin
    case (pre_sel_i)
      2'b00:   fine_nxt_o = div_d[FINE_W-1:0];
      2'b01:   fine_nxt_o = div_d[FINE_W+1:2];
      default: fine_nxt_o = div_d[FINE_W+3:4];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  p_div_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(div_q));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] period_i,
  output logic [TMR_W-1:0] tmr_nxt_o,
  output logic             wrap_o
);
  logic [TMR_W-1:0] tmr_q;

  assign wrap_o = tick_i && (tmr_q == period_i);

  always_comb begin
    if (wrap_o)      tmr_nxt_o = '0;
    else if (tick_i) tmr_nxt_o = tmr_q + 1'b1;
    else             tmr_nxt_o = tmr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= '0;
    else         tmr_q <= tmr_nxt_o;
  end

  p_tmr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tmr_q));
endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_o <= '0;
    else if (load_i) shadow_o <= duty_i;
  end

  p_shadow_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(shadow_o));
endmodule

// File: rtl/pwm_postscaler.sv
module pwm_postscaler
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              match_i,
  input  logic [POST_W-1:0] sel_i,
  output logic              irq_o
);
  logic [POST_W-1:0] cnt_q;
  logic              hit;

  assign hit = match_i && (cnt_q >= sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= hit;
      if (hit)          cnt_q <= '0;
      else if (match_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_o,
  output logic              irq_o
);
  logic [TMR_W-1:0]  period_q;
  logic [TMR_W-1:0]  duty_hi_q;
  logic [FINE_W-1:0] duty_lo_q;
  tctrl_t            tctrl_q;

  logic              tick, wrap, pwm_q, pwm_d;
  logic [FINE_W-1:0] fine_nxt;
  logic [TMR_W-1:0]  tmr_nxt;
  logic [DUTY_W-1:0] duty_w, shadow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q  <= '0;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      tctrl_q   <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        ADDR_PERIOD:  period_q  <= wr_data_i;
        ADDR_DUTY_HI: duty_hi_q <= wr_data_i;
        ADDR_CHAN:    duty_lo_q <= wr_data_i[CHAN_LSB +: FINE_W];
        ADDR_TCTRL:   tctrl_q   <= tctrl_t'(wr_data_i[$bits(tctrl_t)-1:0]);
        default: ;
      endcase
    end
  end

  assign duty_w = {duty_hi_q, duty_lo_q};

  pwm_prescaler u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tctrl_q.en),
    .pre_sel_i  (tctrl_q.pre_sel),
    .tick_o     (tick),
    .fine_nxt_o (fine_nxt)
  );

  pwm_timebase u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .period_i  (period_q),
    .tmr_nxt_o (tmr_nxt),
    .wrap_o    (wrap)
  );

  pwm_duty_shadow u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wrap),
    .duty_i   (duty_w),
    .shadow_o (shadow)
  );

  pwm_postscaler u_post (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (wrap),
    .sel_i   (tctrl_q.post_sel),
    .irq_o   (irq_o)
  );

  // look-ahead compare: output reflects the count of the coming cycle
  always_comb begin
    if (!tctrl_q.en)                       pwm_d = 1'b0;
    else if (wrap)                         pwm_d = |duty_w;
    else if ({tmr_nxt, fine_nxt} == shadow) pwm_d = 1'b0;
    else                                   pwm_d = pwm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

  p_rise_at_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> $past(wrap));
  p_zero_duty_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow == '0) |-> !pwm_q);
  p_off_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tctrl_q.en |=> !pwm_q);
endmodule

// File: tb/tb_pwm_gen.sv
module tb_pwm_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       pwm_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pwm_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [7:0]  period;
    logic [9:0]  duty;
    logic [1:0]  ps;
    logic [11:0] exp_hi;
    logic [11:0] exp_tot;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{8'd7, 10'd10,  2'd0, 12'd10, 12'd32},
    '{8'd3, 10'd5,   2'd1, 12'd20, 12'd64},
    '{8'd1, 10'd3,   2'd2, 12'd48, 12'd128},
    '{8'd9, 10'd39,  2'd0, 12'd39, 12'd40},
    '{8'd9, 10'd40,  2'd0, 12'd40, 12'd40},
    '{8'd9, 10'd100, 2'd0, 12'd40, 12'd40},
    '{8'd5, 10'd1,   2'd0, 12'd1,  12'd24},
    '{8'd0, 10'd2,   2'd0, 12'd2,  12'd4},
    '{8'd4, 10'd0,   2'd0, 12'd0,  12'd20},
    '{8'd2, 10'd7,   2'd1, 12'd28, 12'd48}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_duty(input logic [9:0] d);
    wr(2'd1, d[9:2]);
    wr(2'd2, {2'b00, d[1:0], 4'b1011}); // R1: other chan bits ignored
  endtask

  task automatic set_ctrl(input logic [3:0] post, input logic en, input logic [1:0] ps);
    wr(2'd3, {1'b0, post, en, ps});
  endtask

  task automatic wait_irq();
    do @(negedge clk_i); while (!irq_o);
  endtask

  task automatic measure(output int hi, output int tot);
    wait_irq();
    hi = 0; tot = 0;
    do begin
      tot++;
      if (pwm_o) hi++;
      @(negedge clk_i);
    end while (!irq_o);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, tot, cnt;
    bit seen;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk("R9 pwm", pwm_o, 0);
    chk("R9 irq", irq_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VEC[i]) begin
      string tag;
      wr(2'd0, VEC[i].period);
      set_duty(VEC[i].duty);
      set_ctrl(4'd0, 1'b1, VEC[i].ps);
      wait_irq();
      measure(hi, tot);
      if (VEC[i].duty == 0) tag = "R5";
      else if (int'(VEC[i].duty) >= 4 * (int'(VEC[i].period) + 1)) tag = "R6";
      else tag = "R3";
      chk($sformatf("%s high vec%0d", tag, i), hi, int'(VEC[i].exp_hi));
      chk($sformatf("R2 period vec%0d", i), tot, int'(VEC[i].exp_tot));
    end

    // R4: mid-period duty write waits for next boundary
    wr(2'd0, 8'd7);
    set_duty(10'd8);
    set_ctrl(4'd0, 1'b1, 2'd0);
    wait_irq();
    wait_irq();
    hi = 0;
    fork
      begin
        do begin
          if (pwm_o) hi++;
          @(negedge clk_i);
        end while (!irq_o);
      end
      set_duty(10'd20);
    join
    chk("R4 running period keeps old duty", hi, 8);
    measure(hi, tot);
    chk("R4 new duty next period", hi, 20);

    // R7: disabled holds output low, no irq, writes accepted
    set_ctrl(4'd0, 1'b0, 2'd0);
    @(negedge clk_i);
    cnt = 0; seen = 0;
    repeat (100) begin
      if (pwm_o) cnt++;
      if (irq_o) seen = 1;
      @(negedge clk_i);
    end
    chk("R7 pwm low while off", cnt, 0);
    chk("R7 no irq while off", seen, 0);
    set_duty(10'd12);
    set_ctrl(4'd0, 1'b1, 2'd0);
    wait_irq();
    measure(hi, tot);
    chk("R7 duty written while off", hi, 12);

    // R8: postscale S=2 -> irq every third period
    wr(2'd0, 8'd3);
    set_ctrl(4'd2, 1'b1, 2'd0);
    wait_irq();
    measure(hi, tot);
    chk("R8 irq spacing", tot, 48);
    @(negedge clk_i);
    chk("R8 irq width", irq_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule